// File: doc/BRIEF.md
# Register Rename Mapping Tracker

This block records which in-flight write currently owns each architectural register name of a small register set. The set has aliasing: every 32-bit register has a low and a high 16-bit half with its own name. Only ownership tags and counters are kept. No register values are stored or forwarded. A dispatch stage sends one allocation per destination write, carrying a write tag, a register name and a flag that says whether the write fully updates the containing register. A retirement stage sends one invalidation per retiring write. A rename stage asks a combinational lookup which writes produce the value of a source name. Before dispatching an instruction with N writes, the dispatch stage asks whether the tracker has room for N more mappings.

With the default of 8 registers there are 24 names. Name `r` (0..7) is full register `r`. Name `8+2r` is its low half and name `9+2r` is its high half. Tags are 6 bits wide, and tag 0 means "no owner". Allocations and invalidations are fire-and-forget commands with no ready signal, so the block never applies back-pressure. Admission control belongs to the caller, which dispatches only after `query_ok` has been seen high for the instruction's write count. The command buses are accepted on every clock edge where their valid is high.

Top module: `rrt_tracker`

## Requirements
- R1: An allocation of a full register `r` sets the owner of `r`, of its low half `8+2r` and of its high half `9+2r` to the allocation tag on the next edge. An allocation of a half always sets that half's owner.
- R2: An allocation of a half changes the owner of its full register only when `alloc_full` is 1. With `alloc_full` at 0 the full register keeps its previous owner.
- R3: Every allocation adds one to `used_count` and one to `created_count`, which wraps. `peak_count` holds the largest value `used_count` has reached since reset.
- R4: An invalidation clears an entry of its target set only when that entry still holds `retire_tag`. The target set is the target name and its halves, plus the full register of a half target when `retire_full` is 1.
- R5: An invalidation whose target name has no owner changes no entry and leaves `used_count` unchanged. An invalidation whose target is owned lowers `used_count` by one, never below zero.
- R6: `query_ok` is 1 when `capacity` is 0 (no limit). Otherwise it is 1 when `query_count + used_count` is no greater than the capacity, with the capacity taken as `query_count` if that is larger.
- R7: The lookup reports three fixed slots. Slot 0 is the owner of `lookup_reg`. Slot 1 is the owner of its low half and slot 2 the owner of its high half (full registers only). A slot is valid only for a nonzero tag not already reported in a lower slot. Invalid slots read tag 0. Slot i occupies `lookup_tags[6i+5:6i]` and `lookup_valid[i]`.
- R8: A query with `query_valid` high, a nonzero capacity and `query_count` above the capacity raises `capacity` to `query_count` on the next edge. The capacity never falls.
- R9: When an invalidation and an allocation land in the same cycle, the invalidation is applied first and the allocation second. An entry touched by both ends up owned by the allocation tag.
- R10: After reset every entry is unowned, the three counters are zero and `capacity` equals the `CAP_INIT` parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation command strobe |
| alloc_tag | input | TAG_W | Tag of the new write, nonzero |
| alloc_reg | input | ID_W | Register name written |
| alloc_full | input | 1 | Write fully updates the containing register |
| retire_valid | input | 1 | Invalidation command strobe |
| retire_tag | input | TAG_W | Tag of the retiring write |
| retire_reg | input | ID_W | Register name of the retiring write |
| retire_full | input | 1 | Retiring write fully updated the containing register |
| lookup_reg | input | ID_W | Source name to resolve |
| lookup_valid | output | 3 | Per-slot valid of the producer list |
| lookup_tags | output | 3*TAG_W | Producer tags, slot i at bits 6i+5:6i |
| query_valid | input | 1 | Availability query strobe (enables capacity raise) |
| query_count | input | CNT_W | Number of writes of the candidate instruction |
| query_ok | output | 1 | Room for `query_count` more mappings |
| used_count | output | CNT_W | Mappings currently live |
| peak_count | output | CNT_W | High-water mark of `used_count` |
| created_count | output | CNT_W | Mappings created since reset, wrapping |
| capacity | output | CNT_W | Current mapping capacity, 0 meaning no limit |

## Verification
An entry with the wrong owner shows up at the lookup port when that name or its full register is next resolved. It therefore appears in the same cycle as the lookup, and possibly many cycles after the bad write. A wrong used count shows on `used_count` one edge after the faulty command, and it also shifts `query_ok`. A missed super-register or sub-register claim only becomes visible once a later lookup or invalidation touches the aliased name. For that reason the stimulus resolves a random name on every cycle and retires writes with their original flags.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  localparam int unsigned ARCH_REGS_DEF  = 8;
  localparam int unsigned TAG_W_DEF      = 6;
  localparam int unsigned CNT_W_DEF      = 8;
  localparam int unsigned CAP_DEF        = 16;
  localparam int unsigned HALVES_PER_REG = 2;
  localparam int unsigned LK_SLOTS       = 3;

  // Fixed positions of the producer list returned by a lookup.
  typedef enum logic [1:0] {
    SLOT_SELF = 2'd0,
    SLOT_LO   = 2'd1,
    SLOT_HI   = 2'd2
  } lk_slot_e;
endpackage

// File: rtl/rrt_alias_decode.sv
// Turns a register name into the set of table entries it covers:
// the name itself, its halves (full register), and optionally its
// containing full register (half name with with_super set).
module rrt_alias_decode
  import rrt_pkg::*;
#(
  parameter int unsigned NUM_ARCH = ARCH_REGS_DEF,
  localparam int unsigned NUM_IDS = NUM_ARCH * (1 + HALVES_PER_REG),
  localparam int unsigned ID_W    = $clog2(NUM_IDS)
) (
  input  logic [ID_W-1:0]    id,
  input  logic               with_super,
  output logic [NUM_IDS-1:0] mask
);
  localparam logic [ID_W-1:0] NA = ID_W'(NUM_ARCH);

  logic            id_is_full;
  logic [ID_W-1:0] id_parent;

  assign id_is_full = (id < NA);
  assign id_parent  = (id - NA) >> 1;

  for (genvar e = 0; e < NUM_IDS; e++) begin : g_ent
    localparam logic [ID_W-1:0] E = ID_W'(e);
    if (e < NUM_ARCH) begin : g_full
      assign mask[e] = (id == E) || (with_super && !id_is_full && (id_parent == E));
    end else begin : g_half
      localparam logic [ID_W-1:0] P = ID_W'((e - NUM_ARCH) / 2);
      assign mask[e] = (id == E) || (id_is_full && (id == P));
    end
  end
endmodule

// File: rtl/rrt_owner_table.sv
// Ownership storage: one tag per register name, updated by an
// invalidation (applied first) and an allocation (applied second).
module rrt_owner_table
  import rrt_pkg::*;
#(
  parameter int unsigned NUM_ARCH = ARCH_REGS_DEF,
  parameter int unsigned TAG_W    = TAG_W_DEF,
  localparam int unsigned NUM_IDS = NUM_ARCH * (1 + HALVES_PER_REG),
  localparam int unsigned ID_W    = $clog2(NUM_IDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  input  logic [TAG_W-1:0]          alloc_tag,
  input  logic [ID_W-1:0]           alloc_reg,
  input  logic [NUM_IDS-1:0]        alloc_mask,
  input  logic                      inv_valid,
  input  logic [TAG_W-1:0]          inv_tag,
  input  logic [ID_W-1:0]           inv_reg,
  input  logic [NUM_IDS-1:0]        inv_mask,
  output logic                      inv_hit,
  input  logic [ID_W-1:0]           lk_reg,
  output logic [LK_SLOTS-1:0]       lk_valid,
  output logic [LK_SLOTS*TAG_W-1:0] lk_tags
);
  localparam logic [ID_W-1:0] NA = ID_W'(NUM_ARCH);

  logic [NUM_IDS*TAG_W-1:0] tbl_q;
  logic [NUM_IDS*TAG_W-1:0] tbl_d;

  function automatic logic [TAG_W-1:0] pick(input logic [NUM_IDS*TAG_W-1:0] v,
                                            input logic [ID_W-1:0] idx);
    logic [TAG_W-1:0] r;
    r = '0;
    for (int i = 0; i < NUM_IDS; i++)
      if (idx == ID_W'(i)) r = v[i*TAG_W +: TAG_W];
    return r;
  endfunction

  // An invalidation only proceeds when its target name is owned.
  assign inv_hit = inv_valid && (pick(tbl_q, inv_reg) != '0);

  for (genvar e = 0; e < NUM_IDS; e++) begin : g_upd
    logic [TAG_W-1:0] cur;
    logic             clr;
    logic             set;
    assign cur = tbl_q[e*TAG_W +: TAG_W];
    assign clr = inv_hit && inv_mask[e] && (cur == inv_tag);
    assign set = alloc_valid && alloc_mask[e];
    assign tbl_d[e*TAG_W +: TAG_W] = set ? alloc_tag : (clr ? '0 : cur);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tbl_q <= '0;
    else        tbl_q <= tbl_d;
  end

  // Lookup: owner of the name, then owners of its halves, no repeats.
  logic             lk_is_full;
  logic [ID_W-1:0]  lo_id;
  logic [ID_W-1:0]  hi_id;
  logic [TAG_W-1:0] t_self;
  logic [TAG_W-1:0] t_lo;
  logic [TAG_W-1:0] t_hi;
  logic [LK_SLOTS-1:0] v;

  assign lk_is_full = (lk_reg < NA);
  assign lo_id      = NA + (lk_reg << 1);
  assign hi_id      = lo_id + 1'b1;
  assign t_self     = pick(tbl_q, lk_reg);
  assign t_lo       = lk_is_full ? pick(tbl_q, lo_id) : '0;
  assign t_hi       = lk_is_full ? pick(tbl_q, hi_id) : '0;

  always_comb begin
    v = '0;
    v[int'(SLOT_SELF)] = (t_self != '0);
    v[int'(SLOT_LO)]   = (t_lo != '0) && (t_lo != t_self);
    v[int'(SLOT_HI)]   = (t_hi != '0) && (t_hi != t_self) && (t_hi != t_lo);
  end

  assign lk_valid = v;
  assign lk_tags[int'(SLOT_SELF)*TAG_W +: TAG_W] = v[int'(SLOT_SELF)] ? t_self : '0;
  assign lk_tags[int'(SLOT_LO)*TAG_W   +: TAG_W] = v[int'(SLOT_LO)]   ? t_lo   : '0;
  assign lk_tags[int'(SLOT_HI)*TAG_W   +: TAG_W] = v[int'(SLOT_HI)]   ? t_hi   : '0;

  AST_ALLOC_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> (alloc_reg < ID_W'(NUM_IDS)));  // R1
  AST_ALLOC_CLAIMS: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |=> (pick(tbl_q, $past(alloc_reg)) == $past(alloc_tag)));  // R1
  AST_SKIP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_valid && !inv_hit && !alloc_valid) |=> $stable(tbl_q));  // R5
  AST_LOOKUP_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid[int'(SLOT_LO)] |-> (lk_tags[int'(SLOT_LO)*TAG_W +: TAG_W] !=
                                 lk_tags[int'(SLOT_SELF)*TAG_W +: TAG_W]));  // R7
endmodule

// File: rtl/rrt_map_counter.sv
// Live, peak and created mapping counts plus the growable capacity.
module rrt_map_counter
  import rrt_pkg::*;
#(
  parameter int unsigned CNT_W    = CNT_W_DEF,
  parameter int unsigned CAP_INIT = CAP_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec_req,
  input  logic             q_valid,
  input  logic [CNT_W-1:0] q_count,
  output logic             q_ok,
  output logic [CNT_W-1:0] used,
  output logic [CNT_W-1:0] peak,
  output logic [CNT_W-1:0] total,
  output logic [CNT_W-1:0] cap
);
  localparam logic [CNT_W-1:0] CAP_RST = CNT_W'(CAP_INIT);

  logic [CNT_W-1:0] used_q, used_nx, peak_q, total_q, cap_q, eff_cap;
  logic [CNT_W:0]   demand;
  logic             dec;

  assign dec = dec_req && (used_q != '0);

  always_comb begin
    used_nx = used_q;
    if (inc && !dec)      used_nx = used_q + 1'b1;
    else if (!inc && dec) used_nx = used_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      used_q  <= '0;
      peak_q  <= '0;
      total_q <= '0;
      cap_q   <= CAP_RST;
    end else begin
      used_q <= used_nx;
      if (used_nx > peak_q) peak_q <= used_nx;
      if (inc) total_q <= total_q + 1'b1;
      if (q_valid && (cap_q != '0) && (q_count > cap_q)) cap_q <= q_count;
    end
  end

  // A single instruction wider than the capacity sees the raised value.
  assign eff_cap = (q_count > cap_q) ? q_count : cap_q;
  assign demand  = {1'b0, q_count} + {1'b0, used_q};
  assign q_ok    = (cap_q == '0) || (demand <= {1'b0, eff_cap});

  assign used  = used_q;
  assign peak  = peak_q;
  assign total = total_q;
  assign cap   = cap_q;

  AST_PEAK_COVERS_USED: assert property (@(posedge clk) disable iff (!rst_n)
    peak_q >= used_q);  // R3
  AST_USED_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec) |-> (used_q != '1));  // R3
  AST_CAP_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q != '0) |=> (cap_q >= $past(cap_q)));  // R8
  AST_UNLIMITED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q == '0) |=> (cap_q == '0));  // R6
endmodule

// File: rtl/rrt_tracker.sv
module rrt_tracker
  import rrt_pkg::*;
#(
  parameter int unsigned NUM_ARCH = ARCH_REGS_DEF,
  parameter int unsigned TAG_W    = TAG_W_DEF,
  parameter int unsigned CNT_W    = CNT_W_DEF,
  parameter int unsigned CAP_INIT = CAP_DEF,
  localparam int unsigned NUM_IDS = NUM_ARCH * (1 + HALVES_PER_REG),
  localparam int unsigned ID_W    = $clog2(NUM_IDS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  input  logic [TAG_W-1:0]          alloc_tag,
  input  logic [ID_W-1:0]           alloc_reg,
  input  logic                      alloc_full,
  input  logic                      retire_valid,
  input  logic [TAG_W-1:0]          retire_tag,
  input  logic [ID_W-1:0]           retire_reg,
  input  logic                      retire_full,
  input  logic [ID_W-1:0]           lookup_reg,
  output logic [LK_SLOTS-1:0]       lookup_valid,
  output logic [LK_SLOTS*TAG_W-1:0] lookup_tags,
  input  logic                      query_valid,
  input  logic [CNT_W-1:0]          query_count,
  output logic                      query_ok,
  output logic [CNT_W-1:0]          used_count,
  output logic [CNT_W-1:0]          peak_count,
  output logic [CNT_W-1:0]          created_count,
  output logic [CNT_W-1:0]          capacity
);
  logic [NUM_IDS-1:0] alloc_mask;
  logic [NUM_IDS-1:0] inv_mask;
  logic               inv_hit;

  rrt_alias_decode #(.NUM_ARCH(NUM_ARCH)) u_alloc_dec (
    .id(alloc_reg), .with_super(alloc_full), .mask(alloc_mask));

  rrt_alias_decode #(.NUM_ARCH(NUM_ARCH)) u_inv_dec (
    .id(retire_reg), .with_super(retire_full), .mask(inv_mask));

  rrt_owner_table #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_reg(alloc_reg),
    .alloc_mask(alloc_mask),
    .inv_valid(retire_valid), .inv_tag(retire_tag), .inv_reg(retire_reg),
    .inv_mask(inv_mask), .inv_hit(inv_hit),
    .lk_reg(lookup_reg), .lk_valid(lookup_valid), .lk_tags(lookup_tags));

  rrt_map_counter #(.CNT_W(CNT_W), .CAP_INIT(CAP_INIT)) u_count (
    .clk(clk), .rst_n(rst_n),
    .inc(alloc_valid), .dec_req(inv_hit),
    .q_valid(query_valid), .q_count(query_count), .q_ok(query_ok),
    .used(used_count), .peak(peak_count), .total(created_count), .cap(capacity));

  AST_ALLOC_TAG_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_valid |-> (alloc_tag != '0));  // R1
endmodule

// File: tb/test_rrt_tracker.sv
`timescale 1ns/1ps
module test_rrt_tracker;
  localparam int NA = 8;
  localparam int NIDS = 24;
  localparam int TW = 6;
  localparam int CW = 8;
  localparam int CAP0 = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, alloc_full = 0, retire_valid = 0, retire_full = 0, query_valid = 0;
  logic [TW-1:0] alloc_tag = '0, retire_tag = '0;
  logic [4:0] alloc_reg = '0, retire_reg = '0, lookup_reg = '0;
  logic [CW-1:0] query_count = '0;
  logic [2:0] lookup_valid, u_lookup_valid;
  logic [3*TW-1:0] lookup_tags, u_lookup_tags;
  logic query_ok, u_query_ok;
  logic [CW-1:0] used_count, peak_count, created_count, capacity;
  logic [CW-1:0] u_used, u_peak, u_created, u_cap;

  always #5 clk = ~clk;

  rrt_tracker i_rrt_tracker (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_reg(alloc_reg), .alloc_full(alloc_full),
    .retire_valid(retire_valid), .retire_tag(retire_tag), .retire_reg(retire_reg), .retire_full(retire_full),
    .lookup_reg(lookup_reg), .lookup_valid(lookup_valid), .lookup_tags(lookup_tags),
    .query_valid(query_valid), .query_count(query_count), .query_ok(query_ok),
    .used_count(used_count), .peak_count(peak_count), .created_count(created_count), .capacity(capacity));

  // Same stimulus, no capacity limit.
  rrt_tracker #(.CAP_INIT(0)) i_rrt_unl (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_tag(alloc_tag), .alloc_reg(alloc_reg), .alloc_full(alloc_full),
    .retire_valid(retire_valid), .retire_tag(retire_tag), .retire_reg(retire_reg), .retire_full(retire_full),
    .lookup_reg(lookup_reg), .lookup_valid(u_lookup_valid), .lookup_tags(u_lookup_tags),
    .query_valid(query_valid), .query_count(query_count), .query_ok(u_query_ok),
    .used_count(u_used), .peak_count(u_peak), .created_count(u_created), .capacity(u_cap));

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference model state.
  int own [NIDS];
  int m_used, m_peak, m_total, m_cap;
  int oq_tag[$], oq_reg[$], oq_full[$];

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit in_set(int e, int t, bit with_super);
    if (e == t) return 1;
    if (t < NA && (e == NA + 2*t || e == NA + 2*t + 1)) return 1;
    if (with_super && t >= NA && e == (t - NA) / 2) return 1;
    return 0;
  endfunction

  task automatic exp_lookup(int r, output int vld, output int tags);
    int s, lo, hi;
    s = (r < NIDS) ? own[r] : 0;
    lo = (r < NA) ? own[NA + 2*r] : 0;
    hi = (r < NA) ? own[NA + 2*r + 1] : 0;
    vld = 0; tags = 0;
    if (s != 0) begin vld |= 1; tags |= s; end
    if (lo != 0 && lo != s) begin vld |= 2; tags |= lo << TW; end
    if (hi != 0 && hi != s && hi != lo) begin vld |= 4; tags |= hi << (2*TW); end
  endtask

  task automatic compare_all();
    int v, t, eff;
    exp_lookup(int'(lookup_reg), v, t);
    chk("R7", "lookup valid", int'(lookup_valid), v);
    chk("R7", "lookup tags", int'(lookup_tags), t);
    eff = (int'(query_count) > m_cap) ? int'(query_count) : m_cap;
    chk("R6", "query_ok", int'(query_ok), int'(m_cap == 0 || int'(query_count) + m_used <= eff));
    chk("R6", "unlimited query_ok", int'(u_query_ok), 1);
    chk("R3", "used", int'(used_count), m_used);
    chk("R3", "peak", int'(peak_count), m_peak);
    chk("R3", "created", int'(created_count), m_total);
    chk("R8", "capacity", int'(capacity), m_cap);
  endtask

  task automatic step_model();
    if (retire_valid && own[retire_reg] != 0) begin
      for (int e = 0; e < NIDS; e++)
        if (in_set(e, int'(retire_reg), retire_full) && own[e] == int'(retire_tag)) own[e] = 0;
      if (m_used > 0) m_used--;
    end
    if (alloc_valid) begin
      for (int e = 0; e < NIDS; e++)
        if (in_set(e, int'(alloc_reg), alloc_full)) own[e] = int'(alloc_tag);
      m_used++;
      m_total = (m_total + 1) % 256;
    end
    if (m_used > m_peak) m_peak = m_used;
    if (query_valid && m_cap != 0 && int'(query_count) > m_cap) m_cap = int'(query_count);
  endtask

  task automatic tick();
    compare_all();
    step_model();
  endtask

  task automatic drv(bit av, int at, int ar, bit af, bit iv, int it, int ir, bit ifl,
                     int lr, bit qv, int qn);
    @(negedge clk);
    alloc_valid = av; alloc_tag = TW'(at); alloc_reg = 5'(ar); alloc_full = af;
    retire_valid = iv; retire_tag = TW'(it); retire_reg = 5'(ir); retire_full = ifl;
    lookup_reg = 5'(lr); query_valid = qv; query_count = CW'(qn);
    #1;
  endtask

  initial begin
    int tagc;
    for (int e = 0; e < NIDS; e++) own[e] = 0;
    m_used = 0; m_peak = 0; m_total = 0; m_cap = CAP0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // Reset state
    chk("R10", "used after reset", int'(used_count), 0);
    chk("R10", "capacity after reset", int'(capacity), CAP0);
    chk("R10", "lookup reg0 after reset", int'(lookup_valid), 0);

    drv(1, 5, 2, 0, 0, 0, 0, 0, 0, 0, 0); tick();
    drv(1, 7, 12, 0, 0, 0, 0, 0, 12, 0, 0);
    chk("R1", "low half owner after full alloc", int'(lookup_tags[5:0]), 5);
    tick();
    drv(1, 9, 13, 1, 0, 0, 0, 0, 2, 0, 0);
    chk("R2", "partial write keeps super", int'(lookup_tags[5:0]), 5);
    chk("R2", "partial write sets half", int'(lookup_valid), 3);
    tick();
    drv(0, 0, 0, 0, 1, 5, 2, 1, 2, 0, 0);
    chk("R2", "full-flag half write claims super", int'(lookup_tags[5:0]), 9);
    tick();
    drv(0, 0, 0, 0, 1, 7, 12, 0, 2, 0, 0);
    chk("R4", "stale tag clears nothing", int'(lookup_tags), (7 << 6) | 9);
    chk("R5", "used drops on owned target", int'(used_count), 2);
    tick();
    drv(0, 0, 0, 0, 1, 9, 13, 1, 2, 0, 0);
    chk("R4", "half cleared by its owner", int'(lookup_valid), 1);
    tick();
    drv(1, 11, 5, 0, 0, 0, 0, 0, 2, 0, 0);
    chk("R4", "full-flag retire clears super", int'(lookup_valid), 0);
    tick();
    drv(0, 0, 0, 0, 1, 3, 0, 0, 5, 0, 0); tick();
    drv(1, 12, 5, 0, 1, 11, 5, 0, 5, 0, 0);
    chk("R5", "empty target leaves used", int'(used_count), 1);
    tick();
    drv(0, 0, 0, 0, 0, 0, 0, 0, 5, 1, 4);
    chk("R9", "same-cycle alloc wins", int'(lookup_tags[5:0]), 12);
    chk("R9", "same-cycle used", int'(used_count), 1);
    chk("R6", "room for 4", int'(query_ok), 1);
    tick();
    drv(0, 0, 0, 0, 0, 0, 0, 0, 5, 1, 20);
    chk("R8", "oversized query judged on raised cap", int'(query_ok), 0);
    tick();
    drv(0, 0, 0, 0, 0, 0, 0, 0, 5, 0, 0);
    chk("R8", "capacity raised", int'(capacity), 20);
    tick();

    tagc = 1;
    for (int n = 0; n < 4000; n++) begin
      bit av, af, iv, ifl, qv;
      int at, ar, it, ir;
      av = ($urandom % 3 == 0) && (m_used < 200);
      at = tagc; ar = $urandom % NIDS; af = $urandom % 2;
      iv = 0; it = 0; ir = 0; ifl = 0;
      if (oq_tag.size() > 0 && $urandom % 3 == 0) begin
        int k;
        k = $urandom % oq_tag.size();
        iv = 1; it = oq_tag[k]; ir = oq_reg[k]; ifl = oq_full[k];
        oq_tag.delete(k); oq_reg.delete(k); oq_full.delete(k);
      end else if ($urandom % 10 == 0) begin
        iv = 1; it = 1 + $urandom % 63; ir = $urandom % NIDS; ifl = $urandom % 2;
      end
      qv = ($urandom % 8 == 0);
      drv(av, at, ar, af, iv, it, ir, ifl, $urandom % NIDS, qv, $urandom % 24);
      if (av) begin
        oq_tag.push_back(at); oq_reg.push_back(ar); oq_full.push_back(af);
        tagc = (tagc % 63) + 1;
      end
      tick();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule